// File: doc/BRIEF.md
# Quad Down-Counter Timer Peripheral

This block holds four independent down-counting timer channels behind a small word-addressed register bus. Each channel has a load value that is written straight into its counter, a background reload value used only when the counter underflows, a control byte, a readable live count and a prescaler dividing the clock by 1, 16 or 256. A channel runs free (wrapping to all ones), periodic (reloading from its background value) or one-shot (stopping at zero), in either 32-bit or 16-bit width.

Each underflow sets a raw status bit in a shared interrupt bank. Software masks these bits, reads raw or masked status and clears them by writing ones. A single interrupt line is the OR of the masked status bits. Reads are combinational while the read strobe is high. Writes take effect at the clock edge on which the write strobe is high. Everything runs on one clock with a synchronous active-high reset.

Top module: `tmr_quad_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The bank registers use these byte offsets: mask 0x00, raw status 0x04, masked status 0x08, clear 0x0C. Bit n of each refers to channel n. Channel n uses base 0x10+0x10*n, with load +0x0, live count +0x4, control +0x8 and background reload +0xC. Writing the load register sets the count at once, and the load, control and reload registers read back what was written.
- R3: While control bit 7 (enable) is set, the count drops by one on each prescaled tick. While the channel is disabled the count holds.
- R4: Control bits 3:2 set the prescale: 00 gives one tick per cycle, 01 one per 16 cycles and 10 or 11 one per 256 cycles. Counting starts a full period after a control or load write.
- R5: In periodic mode (bit 6 set, bit 0 clear), a tick that finds the count at zero reloads the background value and sets the channel's raw status bit.
- R6: In free-running mode (bits 6 and 0 clear), a tick at zero wraps the count to the all-ones value of the selected width and sets raw status.
- R7: In one-shot mode (bit 0 set, which takes precedence over bit 6), a tick at zero sets raw status, clears control bit 7 and leaves the count at zero.
- R8: With control bit 1 clear the channel is 16 bits wide. Loaded and reloaded values keep only their low half, and the count wraps to 0xFFFF.
- R9: Writing the background reload register leaves the live count unchanged.
- R10: Masked status equals raw status AND mask, and `irq` is high exactly when some masked bit is set.
- R11: Writing 1 to a bit of the clear register clears that raw bit. Writing 0 has no effect, and writes to the raw and masked status registers are ignored.
- R12: Control bits 5:4, the clear register, offsets beyond the last channel and addresses not aligned to a word all read zero. Writes to any of these locations are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when `bus_rd` is low |
| irq | output | 1 | OR of masked status bits |

## Verification
The counting path is driven through a table of load, reload and control settings. The settings cover each run mode in both widths and all four prescale codes. Every setting is read back after a cycle count chosen to land just before or just after a tick or an underflow. Paired reads taken one cycle apart separate a correct prescale period from an off-by-one. Loads of 1 and 2 separate wrapping, reloading and stopping, because each of these produces a different count two cycles after zero. Directed cases then check the interrupt bank: clearing with zeros, writes to the read-only status registers, and the effect of the mask on `irq`.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_W = 8;
    localparam int PS_W   = 8;

    typedef struct packed {
        logic       en;
        logic       periodic;
        logic [1:0] rsv;
        logic [1:0] psel;
        logic       wide;
        logic       oneshot;
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        RUN_FREE     = 2'd0,
        RUN_PERIODIC = 2'd1,
        RUN_ONESHOT  = 2'd2
    } tmr_run_e;

    function automatic tmr_run_e run_mode(input tmr_ctrl_t c);
        if (c.oneshot)       return RUN_ONESHOT;
        else if (c.periodic) return RUN_PERIODIC;
        else                 return RUN_FREE;
    endfunction

    function automatic logic [PS_W-1:0] ps_terminal(input logic [1:0] sel);
        case (sel)
            2'b00:   return PS_W'(0);
            2'b01:   return PS_W'(15);
            default: return PS_W'(255);
        endcase
    endfunction

    function automatic logic [31:0] width_mask(input logic wide);
        return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       restart,
    input  logic [1:0] psel,
    output logic       tick
);
    logic [PS_W-1:0] pcnt_q;

    assign tick = en && (pcnt_q == ps_terminal(psel));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt_q <= '0;
        end else if (en) begin
            pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
        end
    end

    // R4: with any division above one, ticks never come back to back
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart && psel != 2'b00) |=> !tick);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_load,
    input  logic              wr_ctrl,
    input  logic              wr_bg,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] bg_o,
    output logic [DATA_W-1:0] count_o,
    output logic              evt_o
);
    tmr_ctrl_t         ctrl_q;
    tmr_ctrl_t         ctrl_d;
    tmr_run_e          mode;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] bg_q;
    logic [DATA_W-1:0] wmask;
    logic              tick;
    logic              at_zero;

    assign mode    = run_mode(ctrl_q);
    assign wmask   = DATA_W'(width_mask(ctrl_q.wide));
    assign at_zero = (count_q & wmask) == '0;
    assign evt_o   = tick && at_zero;

    always_comb begin
        ctrl_d     = tmr_ctrl_t'(wdata[CTRL_W-1:0]);
        ctrl_d.rsv = 2'b00;
    end

    tmr_prescale u_ps (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.en),
        .restart (wr_ctrl || wr_load),
        .psel    (ctrl_q.psel),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            count_q <= '0;
            load_q  <= '0;
            bg_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_d;
            end else if (evt_o && mode == RUN_ONESHOT) begin
                ctrl_q.en <= 1'b0;
            end

            if (wr_load) begin
                load_q  <= wdata;
                count_q <= wdata & wmask;
            end else if (tick) begin
                if (at_zero) begin
                    case (mode)
                        RUN_PERIODIC: count_q <= bg_q & wmask;
                        RUN_FREE:     count_q <= wmask;
                        default:      count_q <= '0;
                    endcase
                end else begin
                    count_q <= (count_q - 1'b1) & wmask;
                end
            end

            if (wr_bg) begin
                bg_q <= wdata;
            end
        end
    end

    assign ctrl_o  = ctrl_q;
    assign load_o  = load_q;
    assign bg_o    = bg_q;
    assign count_o = count_q & wmask;

    // R3: a disabled channel keeps its count unless software loads it
    p_hold_when_off_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !wr_load) |=> $stable(count_q));

    // R3: a tick on a non-zero count steps it down by exactly one
    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !at_zero && !wr_load && !wr_ctrl) |=> count_o == $past(count_o) - 1'b1);

    // R6: free-running underflow lands on the width's all-ones value
    p_wrap_to_max_r6: assert property (@(posedge clk) disable iff (rst)
        (evt_o && mode == RUN_FREE && !wr_load && !wr_ctrl) |=> count_o == $past(wmask));

    // R7: one-shot underflow stops the channel at zero
    p_oneshot_halt_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_o && mode == RUN_ONESHOT && !wr_load && !wr_ctrl) |=> (!ctrl_q.en && count_q == '0));

endmodule

// File: rtl/tmr_irq_bank.sv
module tmr_irq_bank #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] evt,
    input  logic           wr_mask,
    input  logic           wr_clr,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] raw_o,
    output logic           irq
);
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] raw_q;
    logic [NCH-1:0] clr_bits;

    assign clr_bits = wr_clr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (wr_mask) mask_q <= wdata;
            raw_q <= (raw_q & ~clr_bits) | evt;
        end
    end

    assign mask_o = mask_q;
    assign raw_o  = raw_q;
    assign irq    = |(raw_q & mask_q);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R5: a raw bit only rises after its channel underflowed
        p_raw_source_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(raw_q[i]) |-> $past(evt[i]));
        // R11: a write-one clear without a concurrent event drops the bit
        p_clear_r11: assert property (@(posedge clk) disable iff (rst)
            (wr_clr && wdata[i] && !evt[i]) |=> !raw_q[i]);
    end

endmodule

// File: rtl/tmr_quad_top.sv
module tmr_quad_top
    import tmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0] blk;
    logic [1:0]       word;
    logic             aligned;

    assign blk     = bus_addr[ADDR_W-1:4];
    assign word    = bus_addr[3:2];
    assign aligned = bus_addr[1:0] == 2'b00;

    logic [CTRL_W-1:0] ch_ctrl  [NCH];
    logic [DATA_W-1:0] ch_load  [NCH];
    logic [DATA_W-1:0] ch_bg    [NCH];
    logic [DATA_W-1:0] ch_count [NCH];
    logic [NCH-1:0]    ch_evt;
    logic [NCH-1:0]    mask;
    logic [NCH-1:0]    raw;
    logic              bank_wr;

    assign bank_wr = bus_wr && aligned && blk == '0;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel_wr;
        assign sel_wr = bus_wr && aligned && blk == BLK_W'(i + 1);

        tmr_channel #(.DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_load (sel_wr && word == 2'd0),
            .wr_ctrl (sel_wr && word == 2'd2),
            .wr_bg   (sel_wr && word == 2'd3),
            .wdata   (bus_wdata),
            .ctrl_o  (ch_ctrl[i]),
            .load_o  (ch_load[i]),
            .bg_o    (ch_bg[i]),
            .count_o (ch_count[i]),
            .evt_o   (ch_evt[i])
        );
    end

    tmr_irq_bank #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .evt     (ch_evt),
        .wr_mask (bank_wr && word == 2'd0),
        .wr_clr  (bank_wr && word == 2'd3),
        .wdata   (bus_wdata[NCH-1:0]),
        .mask_o  (mask),
        .raw_o   (raw),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && aligned) begin
            if (blk == '0) begin
                case (word)
                    2'd0:    bus_rdata = DATA_W'(mask);
                    2'd1:    bus_rdata = DATA_W'(raw);
                    2'd2:    bus_rdata = DATA_W'(raw & mask);
                    default: bus_rdata = '0;
                endcase
            end
            for (int i = 0; i < NCH; i++) begin
                if (blk == BLK_W'(i + 1)) begin
                    case (word)
                        2'd0:    bus_rdata = ch_load[i];
                        2'd1:    bus_rdata = ch_count[i];
                        2'd2:    bus_rdata = DATA_W'(ch_ctrl[i]);
                        default: bus_rdata = ch_bg[i];
                    endcase
                end
            end
        end
    end

    // R10: the interrupt line follows the masked status bits
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
        (raw & mask) == '0 |-> !irq);

    // R12: a misaligned read never returns data
    p_misaligned_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !aligned) |-> bus_rdata == '0);

endmodule

// File: tb/tmr_quad_top_tb.sv
module tmr_quad_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tmr_quad_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    localparam int NV = 12;
    localparam logic [31:0] V_BG   [NV] = '{0, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0};
    localparam logic [31:0] V_LOAD [NV] = '{5, 2, 32'h12345, 1, 1, 10, 10, 10, 10, 2, 7, 10};
    localparam logic [7:0]  V_CTRL [NV] = '{8'h82, 8'h82, 8'h80, 8'h80, 8'hC2, 8'h86,
                                           8'h86, 8'h8A, 8'h8A, 8'h83, 8'h02, 8'h8E};
    localparam int          V_WAIT [NV] = '{3, 4, 0, 3, 4, 15, 16, 255, 256, 5, 10, 256};
    localparam logic [31:0] V_EXP  [NV] = '{2, 32'hFFFF_FFFE, 32'h2345, 32'hFFFE, 1, 10,
                                           9, 10, 9, 0, 7, 9};
    localparam string       V_REQ  [NV] = '{"R3", "R6", "R8", "R8", "R5", "R4",
                                           "R4", "R4", "R4", "R7", "R3", "R4"};

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: every register reads zero out of reset
        for (int a = 0; a < 8'h50; a += 4) rd_chk("R1", 8'(a), 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // table walk: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic [7:0] base;
            base = 8'(8'h10 + 8'h10 * (v % 4));
            wr(base + 8'h8, 32'h0);
            wr(base + 8'hC, V_BG[v]);
            wr(base + 8'h0, V_LOAD[v]);
            wr(base + 8'h8, {24'h0, V_CTRL[v]});
            repeat (V_WAIT[v]) @(negedge clk);
            rd_chk(V_REQ[v], base + 8'h4, V_EXP[v]);
        end

        // R7: one-shot row (channel 1) cleared its enable bit
        rd_chk("R7 ctrl", 8'h28, 32'h03);

        // R2 / R9: readback and reload write leaving the count alone
        wr(8'h28, 32'h0);
        wr(8'h20, 32'd50);
        wr(8'h2C, 32'd7);
        rd_chk("R9", 8'h24, 32'd50);
        rd_chk("R2 bg", 8'h2C, 32'd7);
        rd_chk("R2 load", 8'h20, 32'd50);
        wr(8'h28, 32'hC6);
        rd_chk("R2 ctrl", 8'h28, 32'hC6);

        // R12: reserved control bits and reserved offsets
        wr(8'h38, 32'h30);
        rd_chk("R12 ctrl", 8'h38, 32'h0);
        rd_chk("R12 hole", 8'h50, 32'h0);
        rd_chk("R12 icr", 8'h0C, 32'h0);
        rd_chk("R12 misaligned", 8'h25, 32'h0);

        // interrupt bank: quiesce every channel, then clear
        for (int c = 0; c < 4; c++) wr(8'(8'h18 + 8'h10 * c), 32'h0);
        wr(8'h0C, 32'hF);
        rd_chk("R11 clear all", 8'h04, 32'h0);

        wr(8'h30, 32'h0);
        wr(8'h38, 32'h83);
        repeat (2) @(negedge clk);
        rd_chk("R5 raw", 8'h04, 32'h4);
        rd_chk("R10 masked off", 8'h08, 32'h0);
        chk("R10 irq off", {31'h0, irq}, 32'h0);
        wr(8'h00, 32'h4);
        rd_chk("R10 masked", 8'h08, 32'h4);
        chk("R10 irq on", {31'h0, irq}, 32'h1);
        wr(8'h0C, 32'h3);
        rd_chk("R11 zero bits", 8'h04, 32'h4);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h0);
        rd_chk("R11 ro status", 8'h04, 32'h4);
        wr(8'h0C, 32'h4);
        rd_chk("R11 cleared", 8'h04, 32'h0);
        chk("R11 irq low", {31'h0, irq}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule